// File: doc/BRIEF.md
# Timer Output Compare Channel

One compare channel that sits beside a shared up-counter. Each cycle that the counter advances, the channel checks the counter value against its own 16-bit compare value. It then drives a registered output pin according to a 3-bit compare mode. The modes cover a one-shot set, a one-shot clear, a toggle, two modes that are re-armed when the counter wraps to zero, two pulse-width modes timed against an externally supplied period-end strobe, and a forced-low idle mode. The same event also produces a one-cycle compare flag.

Software loads the compare value one byte at a time. A low-byte write is parked in a holding byte. The high-byte write forms the full value. In the three one-shot modes the full value takes over at once. In every other mode it waits until the counter passes through zero, so a running waveform never sees a half-updated threshold. A build-time switch turns the channel into the period-owning channel. That variant has no pulse-width modes, and in up/down counting it raises its flag at zero rather than on a match.

Top module: `occ_channel`

## Requirements
- R1: On a counting cycle (`tick_i`=1) where `cnt_i` equals the compare value in force, mode 0 drives the pin high, mode 1 drives it low and mode 2 inverts it. The pin changes on the following clock edge.
- R2: Mode 3 drives high on a match and low on a counting cycle with `cnt_i`=0. Mode 4 does the opposite. When both occur in the same cycle, the match wins.
- R3: Mode 5 drives low on a match and high on a counting cycle with `period_hit_i`=1. Mode 6 does the opposite. When both occur in the same cycle, the match wins.
- R4: Mode 7 drives the pin low on the next edge whether or not the counter is counting. When the channel is built as the period-owning channel (`IS_CHAN0`=1), modes 5 and 6 behave as mode 7.
- R5: A write with `wr_lo_i`=1 only stores the byte. Matches keep using the previous compare value until a write with `wr_hi_i`=1 occurs.
- R6: In modes 0 to 2, a high-byte write makes {high, held low} the compare value from the next cycle on.
- R7: In modes 3 to 6, a high-byte write is held back. It becomes the compare value after the next counting cycle with `cnt_i`=0. That zero cycle still compares against the old value.
- R8: `flag_o` is a one-cycle pulse on the edge after a counting cycle with a match.
- R9: For the period-owning channel with timer mode 3 (up/down), `flag_o` pulses after a counting cycle with `cnt_i`=0 instead of after a match. Timer mode encodings are 0 stopped, 1 free-running, 2 modulo and 3 up/down.
- R10: On non-counting cycles, `flag_o` is low and the pin holds its value, except in mode 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter value is valid and advancing this cycle |
| cnt_i | input | 16 | Shared counter value |
| tmr_mode_i | input | 2 | Timer mode (0 stop, 1 free, 2 modulo, 3 up/down) |
| period_hit_i | input | 1 | Counter is at the end of its period |
| wr_lo_i | input | 1 | Write strobe for the low compare byte |
| wr_hi_i | input | 1 | Write strobe for the high compare byte |
| wr_data_i | input | 8 | Write data byte |
| cmp_mode_i | input | 3 | Compare mode 0..7 |
| pin_o | output | 1 | Registered compare output |
| flag_o | output | 1 | One-cycle compare flag |

## Verification
The bench loads a new threshold in a re-armed mode part-way through a count, then checks that the old value still governs every cycle up to and including the zero cycle. A design that loads immediately would move the edge one period early. A low-byte-only write is followed by counting past both the old and the new value, so a design that leaks the held byte would toggle at the wrong count. Coincident match and zero (or period) events are driven to catch a reversed priority. Two builds run side by side: the period-owning build must hold its pin low in the pulse-width modes, and in up/down counting it must move its flag from the match to the zero point.

// File: rtl/occ_pkg.sv
package occ_pkg;

  typedef enum logic [2:0] {
    CM_SET      = 3'd0,
    CM_CLR      = 3'd1,
    CM_TGL      = 3'd2,
    CM_SET_ZLO  = 3'd3,
    CM_CLR_ZHI  = 3'd4,
    CM_PWM_LO   = 3'd5,
    CM_PWM_HI   = 3'd6,
    CM_IDLE     = 3'd7
  } cm_t;

  typedef enum logic [1:0] {
    TM_STOP = 2'd0,
    TM_FREE = 2'd1,
    TM_MOD  = 2'd2,
    TM_UPDN = 2'd3
  } tm_t;

  function automatic logic cm_direct(input cm_t m);
    return (m == CM_SET) || (m == CM_CLR) || (m == CM_TGL);
  endfunction

endpackage

// File: rtl/occ_cmp_reg.sv
module occ_cmp_reg #(
  parameter int BYTE_W = 8,
  localparam int CW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              direct_i,
  input  logic              load_pt_i,
  output logic [CW-1:0]     active_o
);

  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [CW-1:0]     act_q, act_d;
  logic [CW-1:0]     shd_q, shd_d;
  logic              pend_q, pend_d;
  logic              lo_en, act_en, shd_en, pend_en;
  logic [CW-1:0]     full_w;

  assign full_w = {wr_data_i, lo_q};

  always_comb begin
    lo_en   = wr_lo_i;
    lo_d    = wr_data_i;
    act_en  = 1'b0;
    act_d   = act_q;
    shd_en  = 1'b0;
    shd_d   = shd_q;
    pend_en = 1'b0;
    pend_d  = pend_q;
    if (wr_hi_i) begin
      pend_en = 1'b1;
      if (direct_i) begin
        act_en = 1'b1;
        act_d  = full_w;
        pend_d = 1'b0;
      end else begin
        shd_en = 1'b1;
        shd_d  = full_w;
        pend_d = 1'b1;
      end
    end else if (load_pt_i && pend_q) begin
      act_en  = 1'b1;
      act_d   = shd_q;
      pend_en = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      act_q  <= '0;
      shd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (lo_en)   lo_q   <= lo_d;
      if (act_en)  act_q  <= act_d;
      if (shd_en)  shd_q  <= shd_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign active_o = act_q;

endmodule

// File: rtl/occ_out_ctl.sv
module occ_out_ctl
  import occ_pkg::*;
#(
  parameter bit IS_CHAN0 = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic match_i,
  input  logic zero_i,
  input  logic period_i,
  input  cm_t  mode_i,
  input  tm_t  tmode_i,
  output logic pin_o,
  output logic flag_o
);

  cm_t  eff_mode;
  logic pin_q, pin_d, pin_en;
  logic flg_q, flg_d;
  logic hit, zhit, phit;

  generate
    if (IS_CHAN0) begin : g_chan0
      always_comb begin
        eff_mode = mode_i;
        if (mode_i == CM_PWM_LO || mode_i == CM_PWM_HI) eff_mode = CM_IDLE;
      end
      assign flg_d = tick_i & ((tmode_i == TM_UPDN) ? zero_i : match_i);
    end else begin : g_chanx
      assign eff_mode = mode_i;
      assign flg_d    = tick_i & match_i;
    end
  endgenerate

  assign hit  = tick_i & match_i;
  assign zhit = tick_i & zero_i;
  assign phit = tick_i & period_i;

  always_comb begin
    pin_en = 1'b0;
    pin_d  = pin_q;
    unique case (eff_mode)
      CM_SET:     if (hit) begin pin_en = 1'b1; pin_d = 1'b1; end
      CM_CLR:     if (hit) begin pin_en = 1'b1; pin_d = 1'b0; end
      CM_TGL:     if (hit) begin pin_en = 1'b1; pin_d = ~pin_q; end
      CM_SET_ZLO: begin
        if (hit)       begin pin_en = 1'b1; pin_d = 1'b1; end
        else if (zhit) begin pin_en = 1'b1; pin_d = 1'b0; end
      end
      CM_CLR_ZHI: begin
        if (hit)       begin pin_en = 1'b1; pin_d = 1'b0; end
        else if (zhit) begin pin_en = 1'b1; pin_d = 1'b1; end
      end
      CM_PWM_LO: begin
        if (hit)       begin pin_en = 1'b1; pin_d = 1'b0; end
        else if (phit) begin pin_en = 1'b1; pin_d = 1'b1; end
      end
      CM_PWM_HI: begin
        if (hit)       begin pin_en = 1'b1; pin_d = 1'b1; end
        else if (phit) begin pin_en = 1'b1; pin_d = 1'b0; end
      end
      default:    begin pin_en = 1'b1; pin_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      flg_q <= 1'b0;
    end else begin
      if (pin_en) pin_q <= pin_d;
      flg_q <= flg_d;
    end
  end

  assign pin_o  = pin_q;
  assign flag_o = flg_q;

endmodule

// File: rtl/occ_channel.sv
module occ_channel
  import occ_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter bit IS_CHAN0 = 1'b0,
  localparam int CW      = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [1:0]        tmr_mode_i,
  input  logic              period_hit_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [2:0]        cmp_mode_i,
  output logic              pin_o,
  output logic              flag_o
);

  logic [1:0]    rs_q;
  logic          rst_n_s;
  logic [CW-1:0] active_q;
  logic          match_w, zero_w;
  cm_t           mode_w;
  tm_t           tmode_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign mode_w  = cm_t'(cmp_mode_i);
  assign tmode_w = tm_t'(tmr_mode_i);
  assign match_w = (cnt_i == active_q);
  assign zero_w  = (cnt_i == '0);

  occ_cmp_reg #(.BYTE_W(BYTE_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_lo_i   (wr_lo_i),
    .wr_hi_i   (wr_hi_i),
    .wr_data_i (wr_data_i),
    .direct_i  (cm_direct(mode_w)),
    .load_pt_i (tick_i & zero_w),
    .active_o  (active_q)
  );

  occ_out_ctl #(.IS_CHAN0(IS_CHAN0)) u_out (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick_i   (tick_i),
    .match_i  (match_w),
    .zero_i   (zero_w),
    .period_i (period_hit_i),
    .mode_i   (mode_w),
    .tmode_i  (tmode_w),
    .pin_o    (pin_o),
    .flag_o   (flag_o)
  );

endmodule

// File: rtl/occ_channel_chk.sv
module occ_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic [1:0]    tmode,
  input logic          wr_lo,
  input logic          wr_hi,
  input logic [2:0]    mode,
  input logic [CW-1:0] active,
  input logic          pin,
  input logic          flag
);

  a_r1_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 3'd0 && cnt == active) |=> pin);

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 3'd1 && cnt == active) |=> !pin);

  a_r1_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 3'd2 && cnt == active) |=> (pin != $past(pin)));

  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7) |=> !pin);

  a_r5_lo_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi && !(tick && cnt == '0)) |=> $stable(active));

  a_r8_flag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == active && tmode != 2'd3) |=> flag);

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && mode != 3'd7) |=> ($stable(pin) && !flag));

endmodule

bind occ_channel occ_channel_chk #(.CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_s),
  .tick   (tick_i),
  .cnt    (cnt_i),
  .tmode  (tmr_mode_i),
  .wr_lo  (wr_lo_i),
  .wr_hi  (wr_hi_i),
  .mode   (cmp_mode_i),
  .active (active_q),
  .pin    (pin_o),
  .flag   (flag_o)
);

// File: tb/occ_channel_bench.sv
module occ_channel_bench;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic [15:0] cnt;
  logic [1:0]  tmode;
  logic        ph;
  logic        wl, wh;
  logic [7:0]  wd;
  logic [2:0]  mode;
  logic        pin_x, flag_x, pin_0, flag_0;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  occ_channel #(.BYTE_W(8), .IS_CHAN0(1'b0)) u_occ_channel (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_i(cnt), .tmr_mode_i(tmode),
    .period_hit_i(ph), .wr_lo_i(wl), .wr_hi_i(wh), .wr_data_i(wd),
    .cmp_mode_i(mode), .pin_o(pin_x), .flag_o(flag_x)
  );

  occ_channel #(.BYTE_W(8), .IS_CHAN0(1'b1)) u_occ_channel_c0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_i(cnt), .tmr_mode_i(tmode),
    .period_hit_i(ph), .wr_lo_i(wl), .wr_hi_i(wh), .wr_data_i(wd),
    .cmp_mode_i(mode), .pin_o(pin_0), .flag_o(flag_0)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic        pin;
    logic [15:0] act;
    logic [15:0] shd;
    logic [7:0]  lo;
    logic        pend;
  } mdl_t;

  typedef struct {
    int    due;
    logic  pin [2];
    logic  flg [2];
    string tag;
  } exp_t;

  mdl_t mdl [2];
  exp_t sb [$];

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Expected outputs follow the requirement text directly.
  task automatic model(input int i, output logic fl);
    logic [2:0] em;
    logic       mt, zr, pe;
    logic [15:0] nv;
    mt = tick && (cnt == mdl[i].act);
    zr = tick && (cnt == 16'h0000);
    pe = tick && ph;
    em = mode;
    if (i == 0 && (mode == 3'd5 || mode == 3'd6)) em = 3'd7;
    case (em)
      3'd0: if (mt) mdl[i].pin = 1'b1;
      3'd1: if (mt) mdl[i].pin = 1'b0;
      3'd2: if (mt) mdl[i].pin = !mdl[i].pin;
      3'd3: mdl[i].pin = mt ? 1'b1 : (zr ? 1'b0 : mdl[i].pin);
      3'd4: mdl[i].pin = mt ? 1'b0 : (zr ? 1'b1 : mdl[i].pin);
      3'd5: mdl[i].pin = mt ? 1'b0 : (pe ? 1'b1 : mdl[i].pin);
      3'd6: mdl[i].pin = mt ? 1'b1 : (pe ? 1'b0 : mdl[i].pin);
      default: mdl[i].pin = 1'b0;
    endcase
    fl = (i == 0 && tmode == 2'd3) ? zr : mt;
    nv = {wd, mdl[i].lo};
    if (wh) begin
      if (mode <= 3'd2) begin mdl[i].act = nv; mdl[i].pend = 1'b0; end
      else begin mdl[i].shd = nv; mdl[i].pend = 1'b1; end
    end else if (zr && mdl[i].pend) begin
      mdl[i].act = mdl[i].shd;
      mdl[i].pend = 1'b0;
    end
    if (wl) mdl[i].lo = wd;
  endtask

  // Driver: called just after a falling edge, returns after the next one.
  task automatic drv(input logic t, input logic [15:0] c, input logic p, input string tag);
    exp_t e;
    logic f0, f1;
    tick = t; cnt = c; ph = p;
    model(0, f0);
    model(1, f1);
    e.due = cyc + 1;
    e.pin[0] = mdl[0].pin; e.pin[1] = mdl[1].pin;
    e.flg[0] = f0;         e.flg[1] = f1;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    wl = 1'b0; wh = 1'b0;
  endtask

  task automatic wr16(input logic [15:0] v, input string tag);
    wl = 1'b1; wd = v[7:0];
    drv(1'b0, cnt, 1'b0, tag);
    wh = 1'b1; wd = v[15:8];
    drv(1'b0, cnt, 1'b0, tag);
  endtask

  task automatic count(input int a, input int b, input int pat, input string tag);
    for (int k = a; k <= b; k++) drv(1'b1, 16'(k), (k == pat), tag);
  endtask

  // Monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "pin", pin_x, e.pin[1]);
      chk(e.tag, "flag", flag_x, e.flg[1]);
      chk(e.tag, "pin_c0", pin_0, e.pin[0]);
      chk(e.tag, "flag_c0", flag_0, e.flg[0]);
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      mdl[i].pin = 0; mdl[i].act = 0; mdl[i].shd = 0; mdl[i].lo = 0; mdl[i].pend = 0;
    end
    rst_n = 0; tick = 0; cnt = 16'h00ff; tmode = 2'd1; ph = 0;
    wl = 0; wh = 0; wd = 0; mode = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10", "reset pin", pin_x, 1'b0);
    chk("R10", "reset flag", flag_x, 1'b0);

    mode = 3'd0; wr16(16'h0005, "R6");
    count(0, 8, -1, "R1");
    mode = 3'd1; count(0, 8, -1, "R1");
    mode = 3'd2; count(0, 7, -1, "R1"); count(0, 7, -1, "R8");
    wl = 1'b1; wd = 8'h09; drv(1'b0, 16'h0003, 1'b0, "R5");
    count(0, 10, -1, "R5");
    wh = 1'b1; wd = 8'h00; drv(1'b0, 16'h0003, 1'b0, "R6");
    count(0, 10, -1, "R6");

    mode = 3'd3; wr16(16'h0003, "R7");
    count(4, 10, -1, "R7"); count(0, 10, -1, "R7");
    drv(1'b1, 16'h0003, 1'b0, "R2");
    mode = 3'd4; count(0, 6, -1, "R2");
    wr16(16'h0000, "R2"); count(0, 4, -1, "R2"); count(0, 4, -1, "R2");

    mode = 3'd5; wr16(16'h0004, "R3");
    count(0, 10, 10, "R3"); count(0, 10, 10, "R3");
    mode = 3'd6; count(0, 10, 10, "R3"); count(0, 10, 10, "R4");
    count(0, 4, 4, "R3");
    for (int k = 0; k < 4; k++) drv(1'b0, 16'h0004, 1'b1, "R10");
    mode = 3'd7; drv(1'b0, 16'h0001, 1'b0, "R4"); count(0, 6, -1, "R4");

    mode = 3'd0; tmode = 2'd3; wr16(16'h0003, "R9");
    count(0, 6, -1, "R9");
    for (int k = 5; k >= 0; k--) drv(1'b1, 16'(k), 1'b0, "R9");
    mode = 3'd2; count(1, 5, -1, "R9");
    for (int k = 4; k >= 0; k--) drv(1'b1, 16'(k), 1'b0, "R9");
    for (int k = 0; k < 3; k++) drv(1'b0, 16'h0003, 1'b0, "R10");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule